// File: doc/BRIEF.md
# DAC Power Mode Controller

This block is the control state machine that sets the power mode of a voltage-output DAC that has an optional on-chip reference. The command decoder in front of it issues one-cycle request strobes: go to normal, go to standby, go to shutdown, and wake. A wake strobe comes from the commands that transfer or load the DAC register. The decoder also supplies a reference-select code. From these inputs the controller drives the enable of the output buffer, the enable of the reference, a high-impedance indication for the analog output, the latched reference-select code, and a flag that marks the output as valid.

There are three modes. In normal, both the buffer and the reference run. In standby, only the reference keeps running and the output floats. In shutdown, both are off and the output floats. When the block returns to normal it holds the valid flag low for a wake-up delay, and the length of that delay depends on the mode being left. Leaving shutdown needs the long delay, because the reference has to restart. Leaving standby needs only the short delay, but only when the reference had already settled. Both delays are parameters, counted in clock cycles.

Top module: `dacpm_ctrl`

## Requirements
- R1: Out of reset the block is in normal mode with ref_sel = 00, and out_valid stays low until LONG_DLY rising edges after rst_n is released. It goes high after that edge.
- R2: The mode outputs are encoded as follows. Normal: buf_en=1, ref_en=1, out_hiz=0. Standby: buf_en=0, ref_en=1, out_hiz=1. Shutdown: buf_en=0, ref_en=0, out_hiz=1. out_valid is 0 in every mode other than normal.
- R3: A shutdown request is accepted from any mode. After that clock edge the block is in shutdown and out_valid is low.
- R4: A standby request is accepted only in normal mode. In shutdown it is ignored completely, so the mode and ref_sel both stay unchanged.
- R5: A normal request and a wake request each return the block from standby or shutdown to normal. A wake request never changes ref_sel.
- R6: A return from shutdown to normal accepted at edge k raises out_valid after edge k+LONG_DLY and not before.
- R7: A return from standby accepted at edge k raises out_valid after edge k+SHORT_DLY, provided that out_valid has been high since the last reset or shutdown.
- R8: If standby was entered before the reference settled (that is, before out_valid was high since the last reset or shutdown), the return from standby uses LONG_DLY.
- R9: A shutdown request during a wake-up countdown aborts the countdown. The next return from shutdown starts a full LONG_DLY countdown.
- R10: A request for the mode the block is already in does not restart the countdown. Normal, standby and shutdown requests still latch ref_sel_in into ref_sel, with the exception stated in R4.
- R11: When several strobes arrive in the same cycle, they are resolved with this priority: shutdown, then standby, then normal, then wake. Only the winner acts.
- R12: ref_sel carries the latched code unchanged. The codes 00, 01, 10 and 11 select nominal references of 1.214 V, 1.940 V, 2.425 V and 3.885 V.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_normal | input | 1 | One-cycle request for normal mode; latches the reference code |
| req_standby | input | 1 | One-cycle request for standby; latches the reference code |
| req_shutdown | input | 1 | One-cycle request for shutdown; latches the reference code |
| req_wake | input | 1 | One-cycle wake from a register transfer or load-both command |
| ref_sel_in | input | REF_SEL_W | Reference-select code that comes with the request |
| buf_en | output | 1 | Output buffer enable |
| ref_en | output | 1 | Reference enable |
| out_hiz | output | 1 | Analog output is high impedance |
| ref_sel | output | REF_SEL_W | Latched reference-select code |
| out_valid | output | 1 | Output valid after the wake-up delay |

## Verification
The bench drives the block with several kinds of input pattern. Single strobes walk through every pair of modes. Repeated strobes for the current mode separate "relatch the code" from "restart the timer". Standby strobes given during shutdown must leave ref_sel untouched. A shutdown strobe in the middle of a countdown, followed by a wake, must produce a full long delay. Standby entered before the reference settles tells the long return path from the short one. Finally, several strobes in the same cycle expose the priority order. A wake strobe that carries a different code shows that waking never relatches the reference.

// File: rtl/dacpm_pkg.sv
package dacpm_pkg;

  typedef enum logic [1:0] {
    PM_NORM = 2'd0,
    PM_STBY = 2'd1,
    PM_SHUT = 2'd2
  } pm_mode_e;

  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_SHUT = 3'd1,
    CMD_STBY = 3'd2,
    CMD_NORM = 3'd3,
    CMD_WAKE = 3'd4
  } pm_cmd_e;

  // Fixed precedence among simultaneous strobes (R11)
  function automatic pm_cmd_e pick_cmd(input logic shut, input logic stby,
                                       input logic norm, input logic wake);
    if (shut)      return CMD_SHUT;
    else if (stby) return CMD_STBY;
    else if (norm) return CMD_NORM;
    else if (wake) return CMD_WAKE;
    else           return CMD_NONE;
  endfunction

  // Whether a return to normal needs the reference restart delay
  function automatic logic needs_long_wait(input pm_mode_e from_mode,
                                           input logic ref_cold);
    return (from_mode == PM_SHUT) || ref_cold;
  endfunction

endpackage

// File: rtl/dacpm_req_arbiter.sv
module dacpm_req_arbiter
  import dacpm_pkg::*;
(
  input  pm_mode_e mode_q,
  input  logic     req_shut,
  input  logic     req_stby,
  input  logic     req_norm,
  input  logic     req_wake,
  output pm_mode_e go_mode,
  output logic     mode_chg,
  output logic     ref_load
);

  pm_cmd_e win;

  always_comb begin
    win      = pick_cmd(req_shut, req_stby, req_norm, req_wake);
    go_mode  = mode_q;
    mode_chg = 1'b0;
    ref_load = 1'b0;
    unique case (win)
      CMD_SHUT: begin
        ref_load = 1'b1;
        if (mode_q != PM_SHUT) begin
          go_mode  = PM_SHUT;
          mode_chg = 1'b1;
        end
      end
      CMD_STBY: begin
        // shutdown swallows a standby strobe entirely (R4)
        if (mode_q == PM_NORM) begin
          go_mode  = PM_STBY;
          mode_chg = 1'b1;
          ref_load = 1'b1;
        end else if (mode_q == PM_STBY) begin
          ref_load = 1'b1;
        end
      end
      CMD_NORM: begin
        ref_load = 1'b1;
        if (mode_q != PM_NORM) begin
          go_mode  = PM_NORM;
          mode_chg = 1'b1;
        end
      end
      CMD_WAKE: begin
        if (mode_q != PM_NORM) begin
          go_mode  = PM_NORM;
          mode_chg = 1'b1;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/dacpm_wake_timer.sv
module dacpm_wake_timer #(
  parameter int LONG_DLY  = 40,
  parameter int SHORT_DLY = 6,
  localparam int CW = $clog2(LONG_DLY + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_long,
  input  logic start_short,
  input  logic abort,
  output logic done
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt_q <= CW'(LONG_DLY);
    else if (abort)       cnt_q <= '0;
    else if (start_long)  cnt_q <= CW'(LONG_DLY);
    else if (start_short) cnt_q <= CW'(SHORT_DLY);
    else if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
  end

  assign done = (cnt_q == '0);

  // a long load sets the full count on the next cycle
  assert_long_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_long && !abort) |=> (cnt_q == CW'(LONG_DLY)));

  // abort leaves no countdown running
  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> done);

endmodule

// File: rtl/dacpm_refsel_reg.sv
module dacpm_refsel_reg #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  assert_code_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q));

endmodule

// File: rtl/dacpm_ctrl.sv
module dacpm_ctrl
  import dacpm_pkg::*;
#(
  parameter int LONG_DLY  = 40,
  parameter int SHORT_DLY = 6,
  parameter int REF_SEL_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_normal,
  input  logic                 req_standby,
  input  logic                 req_shutdown,
  input  logic                 req_wake,
  input  logic [REF_SEL_W-1:0] ref_sel_in,
  output logic                 buf_en,
  output logic                 ref_en,
  output logic                 out_hiz,
  output logic [REF_SEL_W-1:0] ref_sel,
  output logic                 out_valid
);

  pm_mode_e mode_q;
  logic     cold_q;

  // named internal events
  pm_mode_e ev_go_mode;
  logic     ev_mode_chg;
  logic     ev_ref_load;
  logic     ev_to_norm;
  logic     ev_to_shut;
  logic     ev_start_long;
  logic     ev_start_short;
  logic     ev_abort;
  logic     ev_timer_done;

  dacpm_req_arbiter u_arb (
    .mode_q   (mode_q),
    .req_shut (req_shutdown),
    .req_stby (req_standby),
    .req_norm (req_normal),
    .req_wake (req_wake),
    .go_mode  (ev_go_mode),
    .mode_chg (ev_mode_chg),
    .ref_load (ev_ref_load)
  );

  assign ev_to_norm     = ev_mode_chg && (ev_go_mode == PM_NORM);
  assign ev_to_shut     = ev_mode_chg && (ev_go_mode == PM_SHUT);
  assign ev_start_long  = ev_to_norm && needs_long_wait(mode_q, cold_q);
  assign ev_start_short = ev_to_norm && !needs_long_wait(mode_q, cold_q);
  assign ev_abort       = ev_mode_chg && (ev_go_mode != PM_NORM);

  dacpm_wake_timer #(
    .LONG_DLY  (LONG_DLY),
    .SHORT_DLY (SHORT_DLY)
  ) u_tmr (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_long  (ev_start_long),
    .start_short (ev_start_short),
    .abort       (ev_abort),
    .done        (ev_timer_done)
  );

  dacpm_refsel_reg #(.W(REF_SEL_W)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (ev_ref_load),
    .d     (ref_sel_in),
    .q     (ref_sel)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= PM_NORM;
      cold_q <= 1'b1;
    end else begin
      mode_q <= ev_go_mode;
      if (ev_to_shut)     cold_q <= 1'b1;
      else if (out_valid) cold_q <= 1'b0;
    end
  end

  assign buf_en    = (mode_q == PM_NORM);
  assign ref_en    = (mode_q != PM_SHUT);
  assign out_hiz   = (mode_q != PM_NORM);
  assign out_valid = (mode_q == PM_NORM) && ev_timer_done;

  assert_stby_only_from_norm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != PM_STBY) |=> ((mode_q != PM_STBY) || ($past(mode_q) == PM_NORM)));

  assert_shut_any_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_shutdown |=> ((mode_q == PM_SHUT) && !out_valid));

  assert_valid_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (buf_en && ref_en && !out_hiz));

  assert_ref_off_floats_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_en |-> out_hiz);

  assert_wake_starts_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_to_norm |=> !out_valid);

  assert_wake_keeps_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wake && !req_normal && !req_standby && !req_shutdown) |=> $stable(ref_sel));

endmodule

// File: tb/tb_dacpm_ctrl.sv
module tb_dacpm_ctrl;

  localparam int LONG  = 40;
  localparam int SHORT = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_normal = 1'b0, req_standby = 1'b0, req_shutdown = 1'b0, req_wake = 1'b0;
  logic [1:0] ref_sel_in = 2'b00;
  logic       buf_en, ref_en, out_hiz, out_valid;
  logic [1:0] ref_sel;

  always #4 clk = ~clk;

  dacpm_ctrl #(.LONG_DLY(LONG), .SHORT_DLY(SHORT), .REF_SEL_W(2)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_normal(req_normal), .req_standby(req_standby),
    .req_shutdown(req_shutdown), .req_wake(req_wake),
    .ref_sel_in(ref_sel_in),
    .buf_en(buf_en), .ref_en(ref_en), .out_hiz(out_hiz),
    .ref_sel(ref_sel), .out_valid(out_valid)
  );

  typedef struct packed {
    logic       b;
    logic       r;
    logic       z;
    logic       v;
    logic [1:0] s;
  } obs_t;

  obs_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    failures = 0;

  // bench-side model: mode 0 normal, 1 standby, 2 shutdown
  int         m_mode = 0;
  int         m_cyc = 0;
  int         m_vt = LONG;
  bit         m_settled = 0;
  logic [1:0] m_ref = 2'b00;

  task automatic step(input bit s, input bit sb, input bit n, input bit w,
                      input logic [1:0] sel, input string tag);
    obs_t e;
    bit   vb;
    req_shutdown = s; req_standby = sb; req_normal = n; req_wake = w;
    ref_sel_in = sel;
    m_cyc++;
    vb = (m_mode == 0) && (m_cyc - 1 >= m_vt);
    if (vb) m_settled = 1;
    if (s) begin
      m_ref = sel;
      m_mode = 2;
      m_settled = 0;
    end else if (sb) begin
      if (m_mode != 2) begin
        m_ref = sel;
        m_mode = 1;
      end
    end else if (n || w) begin
      if (n) m_ref = sel;
      if (m_mode != 0) begin
        m_vt = m_cyc + ((m_mode == 1 && m_settled) ? SHORT : LONG);
        m_mode = 0;
      end
    end
    e.b = (m_mode == 0);
    e.r = (m_mode != 2);
    e.z = (m_mode != 0);
    e.v = (m_mode == 0) && (m_cyc >= m_vt);
    e.s = m_ref;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic idle(input int cnt, input string tag);
    for (int i = 0; i < cnt; i++) step(0, 0, 0, 0, 2'b00, tag);
  endtask

  // monitor: compare each edge's result against the queued expectation
  always @(posedge clk) begin
    #2;
    if (exp_q.size() > 0) begin
      obs_t  e;
      obs_t  a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = '{b: buf_en, r: ref_en, z: out_hiz, v: out_valid, s: ref_sel};
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s cyc=%0d actual buf/ref/hiz/valid/sel=%b%b%b%b/%b expected=%b%b%b%b/%b",
                 t, m_cyc, a.b, a.r, a.z, a.v, a.s, e.b, e.r, e.z, e.v, e.s);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if ({buf_en, ref_en, out_hiz, out_valid, ref_sel} !== 6'b110000) begin
      failures++;
      $display("FAIL R1 reset actual=%b%b%b%b/%b expected=1100/00",
               buf_en, ref_en, out_hiz, out_valid, ref_sel);
    end
    rst_n = 1'b1;
    idle(LONG + 3, "R1");
    // R10 R12: normal request in normal latches code, no restart
    step(0, 0, 1, 0, 2'b10, "R10");
    idle(2, "R12");
    // R4 R2: standby from normal, relatch in standby
    step(0, 1, 0, 0, 2'b01, "R4");
    idle(3, "R2");
    step(0, 1, 0, 0, 2'b11, "R10");
    idle(1, "R10");
    // R5 R7: wake from settled standby uses the short delay
    step(0, 0, 0, 1, 2'b00, "R5");
    idle(SHORT + 2, "R7");
    // R3 R4: shutdown, ignored standby, relatch by shutdown
    step(1, 0, 0, 0, 2'b00, "R3");
    idle(2, "R2");
    step(0, 1, 0, 0, 2'b10, "R4");
    idle(2, "R4");
    step(1, 0, 0, 0, 2'b01, "R10");
    idle(1, "R10");
    // R6: normal request from shutdown uses the long delay
    step(0, 0, 1, 0, 2'b11, "R6");
    idle(LONG + 2, "R6");
    // R9: abort a countdown, then wake with a full long delay
    step(1, 0, 0, 0, 2'b11, "R3");
    step(0, 0, 0, 1, 2'b00, "R5");
    idle(5, "R9");
    step(1, 0, 0, 0, 2'b11, "R9");
    idle(2, "R9");
    step(0, 0, 0, 1, 2'b01, "R9");
    idle(LONG + 1, "R9");
    // R8: standby before the reference settles
    step(1, 0, 0, 0, 2'b00, "R8");
    step(0, 0, 1, 0, 2'b01, "R6");
    idle(4, "R8");
    step(0, 1, 0, 0, 2'b01, "R8");
    idle(3, "R8");
    step(0, 0, 0, 1, 2'b00, "R8");
    idle(LONG + 1, "R8");
    // R11: simultaneous strobes
    step(1, 1, 1, 1, 2'b10, "R11");
    idle(1, "R11");
    step(0, 0, 1, 1, 2'b01, "R11");
    idle(LONG + 1, "R11");
    step(0, 1, 1, 1, 2'b00, "R11");
    idle(2, "R11");
    step(0, 0, 0, 1, 2'b11, "R7");
    idle(SHORT + 1, "R7");
    @(posedge clk);
    #3;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule